// File: doc/BRIEF.md
# Pulse Classifier and Sampling Mode Selector

This block watches a single asynchronous signal-over-threshold flag from a photodetector front end, plus three asynchronous over-range flags. The three flags come from attenuated copies of the same pulse, one per gain channel. All four inputs are brought into the fast sampling clock domain. The rising edge of the threshold flag is the event trigger, and it issues a start strobe for the short capture at once.

While the flag stays high, a saturating width counter measures the pulse. When the pulse outlasts the short window, the block issues a strobe that requests the long capture. When it also outlasts the long window, a further strobe requests integrated acquisition. The over-range flags are OR-collected over the pulse into a 3-bit classification code, which picks the gain channel to convert.

When the threshold flag falls, the block reports the final mode, the code and the chosen channel together with a one-cycle done strobe. Triggers arriving before it is idle again are dropped.

Top module: `pulse_mode_sorter`

## Requirements
- R1: While reset is high and in the first cycle after it, every output is zero.
- R2: If `sot_async` is first sampled high at clock edge E0 after being low, `start_o` is high for exactly one cycle, after edge E2.
- R3: If the pulse is sampled high on more than SHORT_LIM consecutive edges, `long_o` is high for one cycle, SHORT_LIM cycles after `start_o`. Otherwise `long_o` stays low.
- R4: If the pulse is sampled high on more than LONG_LIM consecutive edges, `integ_o` is high for one cycle, LONG_LIM cycles after `start_o`. Otherwise `integ_o` stays low.
- R5: If the pulse is sampled high on N edges (E0..E(N-1)), `done_o` is high for exactly one cycle, after edge E(N+2).
- R6: `mode_o` reported with `done_o` encodes the width as follows: 0 for N <= SHORT_LIM, 1 for SHORT_LIM < N <= LONG_LIM, and 2 for N > LONG_LIM.
- R7: Bit i of `code_o` is set when `ovr_async[i]` is sampled high on any edge on which the pulse is sampled high. Bit 0 is the highest-gain channel. Over-range flags outside the pulse have no effect.
- R8: `conv_ch_o` equals 2 if code bit 1 is set, else 1 if code bit 0 is set, else 0. For code 3'b001 the middle channel (1) is chosen.
- R9: A rising edge of `sot_async` that follows a single low sample, while the block is still reporting, starts no new event: no start, long, integ or done strobe follows.
- R10: `mode_o`, `code_o` and `conv_ch_o` change only in the cycle in which `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| sot_async | input | 1 | Asynchronous signal-over-threshold flag |
| ovr_async | input | 3 | Asynchronous over-range flags, bit 0 = highest gain |
| start_o | output | 1 | Trigger strobe, start short capture |
| long_o | output | 1 | Strobe requesting long capture |
| integ_o | output | 1 | Strobe requesting integrated acquisition |
| done_o | output | 1 | Result valid strobe at pulse end |
| mode_o | output | 2 | Final acquisition mode |
| code_o | output | 3 | Classification code |
| conv_ch_o | output | 2 | Gain channel selected for conversion |

## Verification
The delay properties assume that each strobe is preceded by a trigger inside the same pulse. They also assume that the threshold flag holds each level for at least one full clock cycle, so that the synchroniser sees every change. The bench drives all inputs on the falling edge and holds every level for at least one cycle. Between events it leaves several low cycles, except in the deliberate single-cycle gap that tests the retrigger guard. Random pulse widths cover all three mode ranges, and directed widths sit on both sides of each limit.

// File: rtl/pms_pkg.sv
package pms_pkg;
  typedef enum logic [1:0] {
    ACQ_SHORT = 2'd0,
    ACQ_LONG  = 2'd1,
    ACQ_INTEG = 2'd2
  } acq_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_MEAS   = 2'd1,
    ST_REPORT = 2'd2
  } sorter_state_e;

  function automatic logic [1:0] pick_channel(input logic [2:0] code);
    if (code[1])      return 2'd2;
    else if (code[0]) return 2'd1;
    else              return 2'd0;
  endfunction
endpackage

// File: rtl/pms_sync.sv
module pms_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= d_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/pms_width_timer.sv
module pms_width_timer
  import pms_pkg::*;
#(
  parameter int SHORT_LIM = 12,
  parameter int LONG_LIM  = 128,
  localparam int CNT_W    = $clog2(LONG_LIM + 2)
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      trig,
  input  logic      measuring,
  input  logic      level,
  output logic      long_go,
  output logic      integ_go,
  output acq_mode_e mode_now
);
  localparam logic [CNT_W-1:0] SAT   = CNT_W'(LONG_LIM + 1);
  localparam logic [CNT_W-1:0] S_LIM = CNT_W'(SHORT_LIM);
  localparam logic [CNT_W-1:0] L_LIM = CNT_W'(LONG_LIM);

  logic [CNT_W-1:0] width_q;
  logic             advance;

  assign advance = measuring && level && (width_q != SAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      width_q  <= '0;
      long_go  <= 1'b0;
      integ_go <= 1'b0;
    end else begin
      long_go  <= advance && (width_q == S_LIM);
      integ_go <= advance && (width_q == L_LIM);
      if (trig)         width_q <= CNT_W'(1);
      else if (advance) width_q <= width_q + CNT_W'(1);
    end
  end

  always_comb begin
    if (width_q > L_LIM)      mode_now = ACQ_INTEG;
    else if (width_q > S_LIM) mode_now = ACQ_LONG;
    else                      mode_now = ACQ_SHORT;
  end
endmodule

// File: rtl/pms_flag_accum.sv
module pms_flag_accum #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           trig,
  input  logic           collect,
  input  logic [NCH-1:0] flags,
  output logic [NCH-1:0] acc
);
  always_ff @(posedge clk) begin
    if (rst)          acc <= '0;
    else if (trig)    acc <= flags;
    else if (collect) acc <= acc | flags;
  end
endmodule

// File: rtl/pulse_mode_sorter.sv
module pulse_mode_sorter
  import pms_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SHORT_LIM   = 12,
  parameter int LONG_LIM    = 128,
  parameter int NCH         = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sot_async,
  input  logic [NCH-1:0] ovr_async,
  output logic           start_o,
  output logic           long_o,
  output logic           integ_o,
  output logic           done_o,
  output logic [1:0]     mode_o,
  output logic [NCH-1:0] code_o,
  output logic [1:0]     conv_ch_o
);
  logic           lvl, lvl_d, trig;
  logic [NCH-1:0] ovr_s, acc;
  acq_mode_e      mode_now;
  sorter_state_e  state;
  logic           measuring;

  pms_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_sync_sot (
    .clk(clk), .rst(rst), .d_in(sot_async), .q_out(lvl)
  );

  pms_sync #(.WIDTH(NCH), .STAGES(SYNC_STAGES)) u_sync_ovr (
    .clk(clk), .rst(rst), .d_in(ovr_async), .q_out(ovr_s)
  );

  assign measuring = (state == ST_MEAS);
  assign trig      = (state == ST_IDLE) && lvl && !lvl_d;

  pms_width_timer #(.SHORT_LIM(SHORT_LIM), .LONG_LIM(LONG_LIM)) u_timer (
    .clk(clk), .rst(rst), .trig(trig), .measuring(measuring), .level(lvl),
    .long_go(long_o), .integ_go(integ_o), .mode_now(mode_now)
  );

  pms_flag_accum #(.NCH(NCH)) u_accum (
    .clk(clk), .rst(rst), .trig(trig), .collect(measuring && lvl),
    .flags(ovr_s), .acc(acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      lvl_d     <= 1'b0;
      start_o   <= 1'b0;
      done_o    <= 1'b0;
      mode_o    <= '0;
      code_o    <= '0;
      conv_ch_o <= '0;
    end else begin
      lvl_d   <= lvl;
      start_o <= trig;
      done_o  <= 1'b0;
      case (state)
        ST_IDLE: if (trig) state <= ST_MEAS;
        ST_MEAS: begin
          if (!lvl) begin
            state     <= ST_REPORT;
            done_o    <= 1'b1;
            mode_o    <= mode_now;
            code_o    <= acc;
            conv_ch_o <= pick_channel(3'(acc));
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pms_checker.sv
module pms_checker #(
  parameter int SHORT_LIM = 12,
  parameter int LONG_LIM  = 128,
  parameter int NCH       = 3,
  localparam int SW       = $clog2(LONG_LIM + 2)
) (
  input logic           clk,
  input logic           rst,
  input logic           start_o,
  input logic           long_o,
  input logic           integ_o,
  input logic           done_o,
  input logic [1:0]     mode_o,
  input logic [NCH-1:0] code_o,
  input logic [1:0]     conv_ch_o
);
  logic [SW-1:0] since_q;

  always_ff @(posedge clk) begin
    if (rst)                                since_q <= '0;
    else if (start_o)                       since_q <= SW'(1);
    else if (since_q != SW'(LONG_LIM + 1) && since_q != '0) since_q <= since_q + SW'(1);
  end

  p_start_single_r2: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);

  p_long_delay_r3: assert property (@(posedge clk) disable iff (rst)
    long_o |-> (since_q == SW'(SHORT_LIM)));

  p_integ_delay_r4: assert property (@(posedge clk) disable iff (rst)
    integ_o |-> (since_q == SW'(LONG_LIM)));

  p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_mode_legal_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (mode_o != 2'd3));

  p_ch_low_gain_r8: assert property (@(posedge clk) disable iff (rst)
    (done_o && code_o[1]) |-> (conv_ch_o == 2'd2));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable({mode_o, code_o, conv_ch_o}) |-> done_o);
endmodule

bind pulse_mode_sorter pms_checker #(
  .SHORT_LIM(SHORT_LIM), .LONG_LIM(LONG_LIM), .NCH(NCH)
) u_chk (
  .clk(clk), .rst(rst), .start_o(start_o), .long_o(long_o),
  .integ_o(integ_o), .done_o(done_o), .mode_o(mode_o),
  .code_o(code_o), .conv_ch_o(conv_ch_o)
);

// File: tb/sim_pulse_mode_sorter.sv
module sim_pulse_mode_sorter;
  localparam int S = 12;
  localparam int L = 128;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sot_async = 1'b0;
  logic [2:0] ovr_async = 3'b000;
  logic       start_o, long_o, integ_o, done_o;
  logic [1:0] mode_o, conv_ch_o;
  logic [2:0] code_o;

  int checks = 0;
  int errors = 0;

  pulse_mode_sorter #(.SHORT_LIM(S), .LONG_LIM(L)) u0 (
    .clk(clk), .rst(rst), .sot_async(sot_async), .ovr_async(ovr_async),
    .start_o(start_o), .long_o(long_o), .integ_o(integ_o), .done_o(done_o),
    .mode_o(mode_o), .code_o(code_o), .conv_ch_o(conv_ch_o)
  );

  always #10 clk = ~clk;

  function automatic logic [1:0] exp_mode(input int n);
    if (n > L)      return 2'd2;
    else if (n > S) return 2'd1;
    else            return 2'd0;
  endfunction

  function automatic logic [1:0] exp_ch(input logic [2:0] c);
    return c[1] ? 2'd2 : (c[0] ? 2'd1 : 2'd0);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Pulse high on edges 0..n-1; if m>0 a second pulse after one low edge.
  // Flags fl on edges [fo, fo+fl_len) inside the first pulse; fl2 during the second.
  task automatic run_event(input int n, input int m, input logic [2:0] fl,
                           input int fo, input int fl_len, input logic [2:0] fl2);
    logic [2:0] ec;
    int jmax;
    ec = (fl_len > 0) ? fl : 3'b000;
    jmax = n + m + 6;
    @(negedge clk);
    sot_async = (n > 0);
    ovr_async = (fo == 0 && fl_len > 0) ? fl : 3'b000;
    for (int j = 0; j <= jmax; j++) begin
      int e;
      @(negedge clk);
      check("R2 start", 8'(start_o), 8'(j == 2));
      check("R3 long", 8'(long_o), 8'(n > S && j == S + 2));
      check("R4 integ", 8'(integ_o), 8'(n > L && j == L + 2));
      check("R5 done", 8'(done_o), 8'(j == n + 2));
      if (j >= n + 2) begin
        check("R6 mode", 8'(mode_o), 8'(exp_mode(n)));
        check("R7 code", 8'(code_o), 8'(ec));
        check("R8 channel", 8'(conv_ch_o), 8'(exp_ch(ec)));
      end
      e = j + 1;
      sot_async = (e < n) || (m > 0 && e > n && e < n + 1 + m);
      if (e >= fo && e < fo + fl_len && e < n) ovr_async = fl;
      else if (m > 0 && e > n && e < n + 1 + m) ovr_async = fl2;
      else ovr_async = 3'b000;
    end
    sot_async = 1'b0;
    ovr_async = 3'b000;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed_sink;
    seed_sink = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    check("R1 reset start", 8'(start_o), 8'd0);
    check("R1 reset done", 8'(done_o), 8'd0);
    check("R1 reset code", 8'(code_o), 8'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 post-reset outputs",
          8'({start_o, long_o, integ_o, done_o, mode_o, code_o}), 8'd0);

    // Directed corners around both limits
    run_event(1, 0, 3'b001, 0, 1, 3'b000);     // R8 code 001 -> channel 1
    run_event(S, 0, 3'b011, 2, 3, 3'b000);
    run_event(S + 1, 0, 3'b100, S, 1, 3'b000);
    run_event(L, 0, 3'b010, 50, 10, 3'b000);
    run_event(L + 1, 0, 3'b111, 0, L + 1, 3'b000);

    // R7: flags while idle are ignored
    @(negedge clk); ovr_async = 3'b111;
    repeat (3) @(negedge clk); ovr_async = 3'b000;
    repeat (4) @(negedge clk);
    run_event(20, 0, 3'b000, 0, 0, 3'b000);

    // R9: retrigger after one low sample is ignored; flags in it ignored
    run_event(20, 15, 3'b001, 3, 2, 3'b110);
    run_event(S + 5, 40, 3'b000, 0, 0, 3'b111);

    // Random mix
    for (int k = 0; k < 30; k++) begin
      int n, fo, fl;
      logic [2:0] f;
      case ($urandom_range(0, 2))
        0: n = $urandom_range(1, S + 2);
        1: n = $urandom_range(S, L + 2);
        default: n = $urandom_range(L - 2, 300);
      endcase
      fo = $urandom_range(0, n - 1);
      fl = $urandom_range(0, n - fo);
      f = 3'($urandom_range(0, 7));
      run_event(n, 0, f, fo, fl, 3'b000);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule